// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On a rising clock edge it can take in a new external address. Two active-low address strobes can start this load. The processor-side strobe counts only while the primary chip enable is active. The controller-side strobe loads whenever it is asserted. After a load, an internal counter produces the next in-burst addresses. The counter is as wide as the burst field, two bits by default, and it advances by one step on each cycle in which the active-low advance input is asserted.

The low address bits then follow one of two orders. In interleaved order they are the starting bits XOR the count. In linear order they are the starting bits plus the count, wrapping within the burst. The order is captured at the load, together with the three chip enables. A registered device-select flag reports whether all three enables were active at that load. A one-bit source flag reports which strobe started the current burst. The memory array, data path and output drivers sit outside this block. Every pin is a plain control or status signal, so the block has no valid/ready handshake.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cur_addr` is 0, `dev_sel` is 0 and `burst_src` is 0.
- R2: If `strobe_proc_n` is 0 and `cen_a_n` is 0 at an edge, then from the next cycle `cur_addr` equals the `ext_addr` sampled at that edge. A load takes precedence over advance.
- R3: If `strobe_proc_n` is 0 while `cen_a_n` is 1, and `strobe_ctrl_n` and `advance_n` are both 1, then `cur_addr`, `dev_sel` and `burst_src` keep their values.
- R4: If `strobe_ctrl_n` is 0 at an edge, `ext_addr` is loaded whatever the values of the chip enables, and `cur_addr` shows it from the next cycle.
- R5: Each edge with `advance_n` at 0 and no load moves the burst count up by one. After four advances the low two bits return to the starting value.
- R6: With `order_linear` at 0 at the load, the low two bits after k advances equal the start bits XOR (k mod 4).
- R7: With `order_linear` at 1 at the load, the low two bits after k advances equal (start bits + k) mod 4.
- R8: Within a burst, the bits of `cur_addr` above the low two never change.
- R9: With no effective strobe and `advance_n` at 1, `cur_addr` holds its value, so the burst is suspended.
- R10: At every load, `dev_sel` becomes 1 exactly when `cen_a_n`=0, `cen_b_n`=0 and `cen_c`=1. Between loads it holds its value.
- R11: When both strobes load in the same cycle, the processor strobe wins and `burst_src` becomes 0. A load from the controller strobe alone sets `burst_src` to 1.
- R12: Changing `order_linear` in the middle of a burst has no effect. The order is fixed at the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_addr | input | ADDR_W | External address |
| strobe_proc_n | input | 1 | Processor-side address strobe, active low, qualified by cen_a_n |
| strobe_ctrl_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| order_linear | input | 1 | Burst order: 1 linear, 0 interleaved; sampled at load |
| cen_a_n | input | 1 | Primary chip enable, active low |
| cen_b_n | input | 1 | Second chip enable, active low |
| cen_c | input | 1 | Third chip enable, active high |
| cur_addr | output | ADDR_W | Current internal address |
| dev_sel | output | 1 | Registered device-select flag |
| burst_src | output | 1 | Strobe that started the burst: 0 processor, 1 controller |

## Verification
The hardest situation to create is a change of `order_linear` in the middle of a burst while the count is past its wrap point. This matters because the low bits then depend on a mode value captured cycles earlier, not on the input currently driven. The bench sweeps every start value in both orders. It advances six times per burst and flips `order_linear` on every advance. This makes any use of the live mode input visible in the low bits. The wrap is checked on the fourth step, and a suspend follows each burst.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } order_e;

  typedef enum logic {
    SRC_PROC = 1'b0,
    SRC_CTRL = 1'b1
  } src_e;
endpackage

// File: rtl/bas_strobe_dec.sv
module bas_strobe_dec
  import bas_pkg::*;
(
  input  logic strobe_proc_n,
  input  logic strobe_ctrl_n,
  input  logic cen_a_n,
  input  logic cen_b_n,
  input  logic cen_c,
  output logic load,
  output src_e src,
  output logic sel_next
);
  logic proc_hit;
  logic ctrl_hit;

  // processor strobe only counts while the primary enable is active
  assign proc_hit = ~strobe_proc_n & ~cen_a_n;
  assign ctrl_hit = ~strobe_ctrl_n;
  assign load     = proc_hit | ctrl_hit;
  assign src      = proc_hit ? SRC_PROC : SRC_CTRL;
  assign sel_next = ~cen_a_n & ~cen_b_n & cen_c;
endmodule

// File: rtl/bas_burst_cnt.sv
module bas_burst_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= '0;
    else if (adv)  count <= count + 1'b1;
  end
endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] start_low,
  input  logic [CNT_W-1:0] count,
  input  order_e           order,
  output logic [CNT_W-1:0] low
);
  logic [CNT_W-1:0] ilv;
  logic [CNT_W-1:0] lin;

  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv
    assign ilv[b] = start_low[b] ^ count[b];
  end

  assign lin = start_low + count;
  assign low = (order == ORD_LINEAR) ? lin : ilv;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              advance_n,
  input  logic              order_linear,
  input  logic              cen_a_n,
  input  logic              cen_b_n,
  input  logic              cen_c,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              dev_sel,
  output logic              burst_src
);
  localparam int UP_W = ADDR_W - CNT_W;

  logic              load;
  src_e              src_d;
  logic              sel_d;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  low;
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  src_e              src_q;
  logic              sel_q;

  bas_strobe_dec u_dec (
    .strobe_proc_n (strobe_proc_n),
    .strobe_ctrl_n (strobe_ctrl_n),
    .cen_a_n       (cen_a_n),
    .cen_b_n       (cen_b_n),
    .cen_c         (cen_c),
    .load          (load),
    .src           (src_d),
    .sel_next      (sel_d)
  );

  bas_burst_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .adv   (~advance_n),
    .count (count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      order_q <= ORD_INTERLEAVE;
      src_q   <= SRC_PROC;
      sel_q   <= 1'b0;
    end else if (load) begin
      base_q  <= ext_addr;
      order_q <= order_e'(order_linear);
      src_q   <= src_d;
      sel_q   <= sel_d;
    end
  end

  bas_order_map #(.CNT_W(CNT_W)) u_map (
    .start_low (base_q[CNT_W-1:0]),
    .count     (count),
    .order     (order_q),
    .low       (low)
  );

  assign cur_addr  = {base_q[ADDR_W-1 -: UP_W], low};
  assign dev_sel   = sel_q;
  assign burst_src = src_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              advance_n,
  input logic              cen_a_n,
  input logic              cen_b_n,
  input logic              cen_c,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              dev_sel,
  input logic              burst_src
);
  logic eff_load;
  assign eff_load = (!strobe_proc_n && !cen_a_n) || !strobe_ctrl_n;

  // R2 / R4: a load shows the sampled address on the next cycle
  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    eff_load |=> cur_addr == $past(ext_addr));

  // R3: gated processor strobe leaves state untouched
  a_r3_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n && cen_a_n && strobe_ctrl_n && advance_n)
    |=> $stable(cur_addr) && $stable(dev_sel) && $stable(burst_src));

  // R5 / R8: an advance changes low bits and keeps upper bits
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_load && !advance_n)
    |=> (cur_addr[ADDR_W-1:CNT_W] == $past(cur_addr[ADDR_W-1:CNT_W]))
        && (cur_addr[CNT_W-1:0] != $past(cur_addr[CNT_W-1:0])));

  // R9: suspend holds the address
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eff_load && advance_n) |=> $stable(cur_addr));

  // R10: select flag follows the enables at a load
  a_r10_sel: assert property (@(posedge clk) disable iff (!rst_n)
    eff_load |=> dev_sel == $past(!cen_a_n && !cen_b_n && cen_c));

  // R11: processor strobe wins when both load
  a_r11_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_proc_n && !cen_a_n) |=> !burst_src);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_addr      (ext_addr),
  .strobe_proc_n (strobe_proc_n),
  .strobe_ctrl_n (strobe_ctrl_n),
  .advance_n     (advance_n),
  .cen_a_n       (cen_a_n),
  .cen_b_n       (cen_b_n),
  .cen_c         (cen_c),
  .cur_addr      (cur_addr),
  .dev_sel       (dev_sel),
  .burst_src     (burst_src)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 17;
  localparam int TIMEOUT = 200000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          strobe_proc_n = 1'b1;
  logic          strobe_ctrl_n = 1'b1;
  logic          advance_n = 1'b1;
  logic          order_linear = 1'b0;
  logic          cen_a_n = 1'b1;
  logic          cen_b_n = 1'b1;
  logic          cen_c = 1'b0;
  logic [AW-1:0] cur_addr;
  logic          dev_sel;
  logic          burst_src;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(2)) i_burst_addr_seq (
    .clk (clk), .rst_n (rst_n), .ext_addr (ext_addr),
    .strobe_proc_n (strobe_proc_n), .strobe_ctrl_n (strobe_ctrl_n),
    .advance_n (advance_n), .order_linear (order_linear),
    .cen_a_n (cen_a_n), .cen_b_n (cen_b_n), .cen_c (cen_c),
    .cur_addr (cur_addr), .dev_sel (dev_sel), .burst_src (burst_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in;
    strobe_proc_n = 1'b1;
    strobe_ctrl_n = 1'b1;
    advance_n     = 1'b1;
  endtask

  initial begin : watchdog
    #(TIMEOUT * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    logic [AW-1:0] a;
    logic [AW-1:0] held;
    logic [1:0]    lowx;

    // R1 reset state
    tick();
    check("R1 addr", cur_addr, 0);
    check("R1 sel", dev_sel, 0);
    rst_n = 1'b1;
    tick();
    check("R1 src", burst_src, 0);
    check("R1 addr after release", cur_addr, 0);

    // sweep start bits, both orders, six advances with mode toggling
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        a = AW'(((s * 37 + m * 91 + 5) << 2) | s);
        ext_addr = a;
        order_linear = m[0];
        cen_a_n = 1'b0; cen_b_n = 1'b0; cen_c = 1'b1;
        if (s[0]) strobe_ctrl_n = 1'b0;
        else      strobe_proc_n = 1'b0;
        tick();
        idle_in();
        check(s[0] ? "R4 load" : "R2 load", cur_addr, a);
        for (int k = 1; k <= 6; k++) begin
          advance_n = 1'b0;
          order_linear = ~order_linear;   // R12: must not matter
          ext_addr = ~a;
          tick();
          lowx = (m == 1) ? 2'((s + k) % 4) : 2'(s ^ (k % 4));
          check(m == 1 ? "R7 R12 linear" : "R6 R12 interleave", cur_addr[1:0], lowx);
          check("R8 upper", cur_addr[AW-1:2], a[AW-1:2]);
          if (k == 4) check("R5 wrap", cur_addr, a);
        end
        idle_in();
        held = cur_addr;
        tick();
        tick();
        check("R9 hold", cur_addr, held);
      end
    end

    // R3 gated processor strobe
    held = cur_addr;
    cen_a_n = 1'b1;
    ext_addr = AW'(17'h1abcd);
    strobe_proc_n = 1'b0;
    tick();
    idle_in();
    check("R3 addr", cur_addr, held);
    check("R3 sel", dev_sel, 1);
    check("R3 src", burst_src, 1);

    // R10 select for all enable combinations, controller strobe
    for (int e = 0; e < 8; e++) begin
      cen_a_n = e[0]; cen_b_n = e[1]; cen_c = e[2];
      ext_addr = AW'(e * 1000 + 3);
      strobe_ctrl_n = 1'b0;
      tick();
      idle_in();
      check("R10 sel", dev_sel, (e == 4) ? 1 : 0);
      check("R4 load any enables", cur_addr, AW'(e * 1000 + 3));
      cen_a_n = ~cen_a_n; cen_c = ~cen_c;
      tick();
      check("R10 sel held", dev_sel, (e == 4) ? 1 : 0);
    end

    // R11 priority and source
    cen_a_n = 1'b0; cen_b_n = 1'b0; cen_c = 1'b1;
    strobe_ctrl_n = 1'b0;
    tick();
    check("R11 ctrl alone", burst_src, 1);
    strobe_proc_n = 1'b0;
    ext_addr = AW'(17'h00155);
    tick();
    check("R11 both", burst_src, 0);
    cen_a_n = 1'b1;
    tick();
    check("R11 both gated", burst_src, 1);

    // R2 load beats advance
    cen_a_n = 1'b0;
    strobe_ctrl_n = 1'b1;
    ext_addr = AW'(17'h0a5a6);
    advance_n = 1'b0;
    tick();
    check("R2 load over advance", cur_addr, AW'(17'h0a5a6));
    idle_in();
    tick();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule